// File: doc/BRIEF.md
# Speculative Load Result Buffer

This block sits between a core's load queue and its first-level cache. It keeps, for every load-queue slot, the line data that a speculative load brought back. That data can later be exposed to the memory system or checked against a fresh copy of the line. Each slot holds two sub-blocks, so a load that straddles a line boundary can be tracked as two halves. A half is addressed by the slot number plus a half bit. On the cache side it is addressed by the combined index `slot*2 + half`.

The core issues four kinds of request on one port. A speculative load fetches its line from the cache. A buffer-only load copies a line that another slot already holds and never touches the cache. An expose re-announces a buffered access to the cache without moving data. A validate refetches the line and reports whether the buffered bytes still match. At most one cache request is outstanding at a time. While it waits, further speculative loads to the same line are merged onto it, and all of them are answered from the single returned line.

Control is a three-state machine. `ST_IDLE` accepts any request. The transition *issue* (a speculative load, expose or validate) goes to `ST_WAIT`. `ST_WAIT` holds one outstanding line request and accepts merges and buffer-only loads. The transition *fill* (a cache response for the outstanding line) goes to `ST_RESP`. `ST_RESP` answers the primary request and then each merged load, one per cycle, and rejects new requests. The transition *drain* (the last item has been answered) goes back to `ST_IDLE`.

Top module: `spec_load_buffer`

## Requirements
- R1: After reset no sub-block is valid, the state is idle, and `resp_valid`, `fwd_valid` and `cache_req_valid` are low. A buffer-only load made right after reset raises `err`.
- R2: In idle, a speculative load (`req_kind`=0) with a legal half reports `req_status`=1 (issued) in the same cycle. In the next cycle `cache_req_valid` is high with `cache_req_kind` equal to the request kind, `cache_req_line`=`req_addr>>OFF_W`, and `cache_req_idx`=`req_slot*2+req_second`.
- R3: While a speculative load is outstanding, a speculative load to the same line reports 2 (merged). A load to another line reports 3 (stalled), as does any load while the outstanding request is an expose or validate, or while the merge list is full.
- R4: One cycle after a cache response whose line matches the outstanding line, `resp_valid` rises. The primary request is answered first, then each merged load in arrival order, one per cycle. A speculative item carries the bytes of the returned line at its own offset and size, zero-extended. Line data is written into an item's sub-block only if that sub-block's stored line still equals the returned line.
- R5: `resp_l1hit` equals the `cache_resp_local` of the fill for speculative items, and is 0 for other kinds.
- R6: A buffer-only load (`req_kind`=1) in idle or wait reports issued. It copies the line from the source slot, taking sub-block 0 if its line matches the request line and otherwise sub-block 1. In the next cycle `fwd_valid` is high with the request's bytes, and no cache request is made.
- R7: A buffer-only load whose line is in neither valid sub-block of the source slot raises `err`, reports status 0, and produces no `fwd_valid`.
- R8: An expose (`req_kind`=2) or validate (`req_kind`=3) whose address or size differs from its sub-block's stored values, or whose sub-block is invalid, raises `err` and makes no cache request.
- R9: A validate response has `resp_pass`=1 when the buffered bytes at the stored offset and size equal the same bytes of the returned line, and 0 otherwise.
- R10: An expose response has `resp_data`=0 and `resp_pass`=0.
- R11: A request for the second half (`req_second`=1) with `req_split`=0, or with a slot or source slot of `NUM_SLOTS` or more, raises `err` and is dropped.
- R12: In `ST_RESP` every legal request reports stalled. In `ST_WAIT` every expose and validate reports stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 0 speculative load, 1 buffer-only load, 2 expose, 3 validate |
| req_slot | input | SLOT_W | Load-queue slot |
| req_second | input | 1 | Selects sub-block 1 (second half) |
| req_split | input | 1 | The access spans two lines |
| req_addr | input | ADDR_W | Byte address of this half |
| req_size | input | SIZE_W | Bytes in this half |
| req_src_slot | input | SLOT_W | Source slot for a buffer-only load |
| req_status | output | 2 | 0 none, 1 issued, 2 merged, 3 stalled |
| err | output | 1 | Request rejected as illegal or mismatched |
| cache_req_valid | output | 1 | Line request to cache |
| cache_req_kind | output | 2 | Kind code of the line request |
| cache_req_line | output | LINE_W | Line address |
| cache_req_idx | output | SLOT_W+1 | slot*2+half |
| cache_resp_valid | input | 1 | Line returned |
| cache_resp_line | input | LINE_W | Returned line address |
| cache_resp_data | input | LINE_BYTES*8 | Returned line bytes |
| cache_resp_local | input | 1 | Line came from the local cache |
| resp_valid | output | 1 | Completion to core |
| resp_kind | output | 2 | Kind of the completed request |
| resp_slot | output | SLOT_W | Slot completed |
| resp_second | output | 1 | Half completed |
| resp_data | output | MAX_LD*8 | Load bytes, little-endian |
| resp_l1hit | output | 1 | Speculative load hit the local cache |
| resp_pass | output | 1 | Validate result |
| fwd_valid | output | 1 | Buffer-only load completion |
| fwd_slot | output | SLOT_W | Slot completed |
| fwd_second | output | 1 | Half completed |
| fwd_data | output | MAX_LD*8 | Forwarded bytes |

## Verification
Speculative loads are tried alone, merged with a second-half load on the same line, and against a load to another line. This separates merging from stalling and shows the dependent ordering. Buffer-only loads are served from source sub-block 0, from source sub-block 1, and from a slot with no match, which tells the two lookup paths apart from the miss error. A fill that arrives after a buffer-only load has moved a slot to another line shows whether the line-match guard protects the sub-block. Validates are tried with equal and with altered data, and exposes and validates with a wrong size or an illegal half, to tell a pass from a fail and a legal request from a rejected one.

// File: rtl/slb_pkg.sv
package slb_pkg;
    typedef enum logic [1:0] {
        K_SPEC   = 2'd0,
        K_FWD    = 2'd1,
        K_EXPOSE = 2'd2,
        K_VALID  = 2'd3
    } slb_kind_e;

    typedef enum logic [1:0] {
        S_NONE    = 2'd0,
        S_ISSUED  = 2'd1,
        S_MERGED  = 2'd2,
        S_STALLED = 2'd3
    } slb_status_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } slb_state_e;
endpackage

// File: rtl/slb_store.sv
module slb_store #(
    parameter int NUM_SLOTS  = 33,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SIZE_W     = 4,
    parameter int NRD        = 4,
    parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    meta_we,
    input  logic [SLOT_W-1:0]       meta_slot,
    input  logic                    meta_half,
    input  logic [ADDR_W-1:0]       meta_addr,
    input  logic [SIZE_W-1:0]       meta_size,
    input  logic                    data_we,
    input  logic [SLOT_W-1:0]       data_slot,
    input  logic                    data_half,
    input  logic [LINE_BYTES*8-1:0] data_line,
    input  logic [SLOT_W-1:0]       rd_slot  [NRD],
    input  logic                    rd_half  [NRD],
    output logic                    rd_valid [NRD],
    output logic [ADDR_W-1:0]       rd_addr  [NRD],
    output logic [SIZE_W-1:0]       rd_size  [NRD],
    output logic [LINE_BYTES*8-1:0] rd_data  [NRD]
);
    localparam int ENTRIES   = 2 * NUM_SLOTS;
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic                 ent_valid [ENTRIES];
    logic [ADDR_W-1:0]    ent_addr  [ENTRIES];
    logic [SIZE_W-1:0]    ent_size  [ENTRIES];
    logic [LINE_BITS-1:0] ent_data  [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) ent_valid[e] <= 1'b0;
        end else if (meta_we && meta_slot <= LAST) begin
            ent_valid[{meta_slot, meta_half}] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (meta_we && meta_slot <= LAST) begin
            ent_addr[{meta_slot, meta_half}] <= meta_addr;
            ent_size[{meta_slot, meta_half}] <= meta_size;
        end
        if (data_we && data_slot <= LAST) begin
            ent_data[{data_slot, data_half}] <= data_line;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic ok;
        assign ok          = rd_slot[g] <= LAST;
        assign rd_valid[g] = ok ? ent_valid[{rd_slot[g], rd_half[g]}] : 1'b0;
        assign rd_addr[g]  = ok ? ent_addr[{rd_slot[g], rd_half[g]}]  : '0;
        assign rd_size[g]  = ok ? ent_size[{rd_slot[g], rd_half[g]}]  : '0;
        assign rd_data[g]  = ok ? ent_data[{rd_slot[g], rd_half[g]}]  : '0;
    end
endmodule

// File: rtl/slb_dep_list.sv
module slb_dep_list #(
    parameter int DEPTH  = 4,
    parameter int SLOT_W = 6,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  logic              push_half,
    input  logic              clear,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              rd_half,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic [SLOT_W-1:0] lst_slot [DEPTH];
    logic              lst_half [DEPTH];
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            lst_slot[cnt_q] <= push_slot;
            lst_half[cnt_q] <= push_half;
        end
    end

    assign count   = cnt_q;
    assign full    = cnt_q == CAP;
    assign rd_slot = (rd_idx < CAP) ? lst_slot[rd_idx] : '0;
    assign rd_half = (rd_idx < CAP) ? lst_half[rd_idx] : 1'b0;
endmodule

// File: rtl/spec_load_buffer.sv
module spec_load_buffer
    import slb_pkg::*;
#(
    parameter int NUM_SLOTS  = 33,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int MAX_LD     = 8,
    parameter int DEP_DEPTH  = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    input  logic [1:0]                                  req_kind,
    input  logic [$clog2(NUM_SLOTS)-1:0]                req_slot,
    input  logic                                        req_second,
    input  logic                                        req_split,
    input  logic [ADDR_W-1:0]                           req_addr,
    input  logic [$clog2(MAX_LD+1)-1:0]                 req_size,
    input  logic [$clog2(NUM_SLOTS)-1:0]                req_src_slot,
    output logic [1:0]                                  req_status,
    output logic                                        err,
    output logic                                        cache_req_valid,
    output logic [1:0]                                  cache_req_kind,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]        cache_req_line,
    output logic [$clog2(NUM_SLOTS):0]                  cache_req_idx,
    input  logic                                        cache_resp_valid,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]        cache_resp_line,
    input  logic [LINE_BYTES*8-1:0]                     cache_resp_data,
    input  logic                                        cache_resp_local,
    output logic                                        resp_valid,
    output logic [1:0]                                  resp_kind,
    output logic [$clog2(NUM_SLOTS)-1:0]                resp_slot,
    output logic                                        resp_second,
    output logic [MAX_LD*8-1:0]                         resp_data,
    output logic                                        resp_l1hit,
    output logic                                        resp_pass,
    output logic                                        fwd_valid,
    output logic [$clog2(NUM_SLOTS)-1:0]                fwd_slot,
    output logic                                        fwd_second,
    output logic [MAX_LD*8-1:0]                         fwd_data
);
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int OFF_W     = $clog2(LINE_BYTES);
    localparam int LINE_W    = ADDR_W - OFF_W;
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int LD_W      = MAX_LD * 8;
    localparam int SIZE_W    = $clog2(MAX_LD + 1);
    localparam int DCNT_W    = $clog2(DEP_DEPTH + 1);
    localparam int NRD       = 4;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    function automatic logic [LD_W-1:0] pick(input logic [LINE_BITS-1:0] ln,
                                             input logic [OFF_W-1:0] off,
                                             input logic [SIZE_W-1:0] sz);
        logic [LD_W-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_LD; i++) begin
            if (i < int'(sz) && int'(off) + i < LINE_BYTES)
                r[8*i +: 8] = ln[8*(int'(off) + i) +: 8];
        end
        return r;
    endfunction

    slb_state_e        state_q, state_d;
    slb_kind_e         kind_q;
    logic [SLOT_W-1:0] prim_slot_q;
    logic              prim_half_q;
    logic [LINE_W-1:0] prim_line_q;
    logic [LINE_BITS-1:0] line_q;
    logic              local_q;
    logic [DCNT_W-1:0] item_q;
    logic              creq_q;
    slb_kind_e         ckind_q;
    logic [LINE_W-1:0] cline_q;
    logic [SLOT_W:0]   cidx_q;
    logic              fwd_q, fwd_half_q;
    logic [SLOT_W-1:0] fwd_slot_q;
    logic [LD_W-1:0]   fwd_data_q;

    slb_kind_e         kind;
    logic [LINE_W-1:0] req_line;
    logic              bad, src_hit0, src_hit1, own_ok;
    logic              do_issue, do_merge, do_fwd;
    slb_status_e       status;

    logic [SLOT_W-1:0]    rd_slot  [NRD];
    logic                 rd_half  [NRD];
    logic                 rd_valid [NRD];
    logic [ADDR_W-1:0]    rd_addr  [NRD];
    logic [SIZE_W-1:0]    rd_size  [NRD];
    logic [LINE_BITS-1:0] rd_data  [NRD];

    logic [SLOT_W-1:0] dep_slot, item_slot;
    logic              dep_half, item_half, dep_full, last_item, fill_we;
    logic [DCNT_W-1:0] dep_cnt, dep_idx;
    slb_kind_e         item_kind;
    logic [LINE_BITS-1:0] src_line;

    assign kind     = slb_kind_e'(req_kind);
    assign req_line = req_addr[ADDR_W-1:OFF_W];

    // read ports: own sub-block, source half 0, source half 1, response item
    assign rd_slot[0] = req_slot;     assign rd_half[0] = req_second;
    assign rd_slot[1] = req_src_slot; assign rd_half[1] = 1'b0;
    assign rd_slot[2] = req_src_slot; assign rd_half[2] = 1'b1;
    assign rd_slot[3] = item_slot;    assign rd_half[3] = item_half;

    assign src_hit0 = rd_valid[1] && rd_addr[1][ADDR_W-1:OFF_W] == req_line;
    assign src_hit1 = rd_valid[2] && rd_addr[2][ADDR_W-1:OFF_W] == req_line;
    assign own_ok   = rd_valid[0] && rd_addr[0] == req_addr && rd_size[0] == req_size;
    assign src_line = src_hit0 ? rd_data[1] : rd_data[2];
    assign bad      = (req_second && !req_split) || req_slot > LAST ||
                      (kind == K_FWD && req_src_slot > LAST);

    // request decode
    always_comb begin
        status   = S_NONE;
        err      = 1'b0;
        do_issue = 1'b0;
        do_merge = 1'b0;
        do_fwd   = 1'b0;
        if (req_valid) begin
            if (bad) begin
                err = 1'b1;
            end else if (state_q == ST_RESP) begin
                status = S_STALLED;
            end else begin
                unique case (kind)
                    K_SPEC: begin
                        if (state_q == ST_IDLE) begin
                            status = S_ISSUED; do_issue = 1'b1;
                        end else if (kind_q == K_SPEC && req_line == prim_line_q && !dep_full) begin
                            status = S_MERGED; do_merge = 1'b1;
                        end else begin
                            status = S_STALLED;
                        end
                    end
                    K_FWD: begin
                        if (src_hit0 || src_hit1) begin
                            status = S_ISSUED; do_fwd = 1'b1;
                        end else begin
                            err = 1'b1;
                        end
                    end
                    K_EXPOSE, K_VALID: begin
                        if (state_q != ST_IDLE) status = S_STALLED;
                        else if (own_ok) begin
                            status = S_ISSUED; do_issue = 1'b1;
                        end else err = 1'b1;
                    end
                endcase
            end
        end
    end
    assign req_status = status;

    // response item selection
    assign dep_idx   = (item_q == '0) ? '0 : item_q - 1'b1;
    assign item_slot = (item_q == '0) ? prim_slot_q : dep_slot;
    assign item_half = (item_q == '0) ? prim_half_q : dep_half;
    assign item_kind = (item_q == '0) ? kind_q : K_SPEC;
    assign last_item = item_q == dep_cnt;
    assign fill_we   = state_q == ST_RESP && item_kind == K_SPEC && rd_valid[3] &&
                       rd_addr[3][ADDR_W-1:OFF_W] == prim_line_q;

    slb_store #(
        .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
        .SIZE_W(SIZE_W), .NRD(NRD), .SLOT_W(SLOT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .meta_we((do_issue && kind == K_SPEC) || do_merge || do_fwd),
        .meta_slot(req_slot), .meta_half(req_second),
        .meta_addr(req_addr), .meta_size(req_size),
        .data_we(do_fwd || fill_we),
        .data_slot(do_fwd ? req_slot : item_slot),
        .data_half(do_fwd ? req_second : item_half),
        .data_line(do_fwd ? src_line : line_q),
        .rd_slot(rd_slot), .rd_half(rd_half), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data)
    );

    slb_dep_list #(.DEPTH(DEP_DEPTH), .SLOT_W(SLOT_W), .CNT_W(DCNT_W)) u_deps (
        .clk(clk), .rst_n(rst_n),
        .push(do_merge), .push_slot(req_slot), .push_half(req_second),
        .clear(state_q == ST_RESP && last_item),
        .rd_idx(dep_idx), .rd_slot(dep_slot), .rd_half(dep_half),
        .count(dep_cnt), .full(dep_full)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (do_issue) state_d = ST_WAIT;
            ST_WAIT: if (cache_resp_valid && cache_resp_line == prim_line_q) state_d = ST_RESP;
            ST_RESP: if (last_item) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;   kind_q <= K_SPEC;
            prim_slot_q <= '0;    prim_half_q <= 1'b0;  prim_line_q <= '0;
            line_q <= '0;         local_q <= 1'b0;      item_q <= '0;
            creq_q <= 1'b0;       ckind_q <= K_SPEC;    cline_q <= '0;  cidx_q <= '0;
            fwd_q <= 1'b0;        fwd_slot_q <= '0;     fwd_half_q <= 1'b0; fwd_data_q <= '0;
        end else begin
            state_q <= state_d;
            creq_q  <= do_issue;
            fwd_q   <= do_fwd;
            if (do_issue) begin
                kind_q <= kind;          prim_slot_q <= req_slot;
                prim_half_q <= req_second; prim_line_q <= req_line;
                ckind_q <= kind;         cline_q <= req_line;
                cidx_q <= {req_slot, req_second};
            end
            if (do_fwd) begin
                fwd_slot_q <= req_slot;  fwd_half_q <= req_second;
                fwd_data_q <= pick(src_line, req_addr[OFF_W-1:0], req_size);
            end
            if (state_q == ST_WAIT && state_d == ST_RESP) begin
                line_q <= cache_resp_data; local_q <= cache_resp_local; item_q <= '0;
            end else if (state_q == ST_RESP) begin
                item_q <= item_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cache_req_valid = creq_q;
        cache_req_kind  = ckind_q;
        cache_req_line  = cline_q;
        cache_req_idx   = cidx_q;
        fwd_valid       = fwd_q;
        fwd_slot        = fwd_slot_q;
        fwd_second      = fwd_half_q;
        fwd_data        = fwd_data_q;
        resp_valid      = state_q == ST_RESP;
        resp_kind       = item_kind;
        resp_slot       = item_slot;
        resp_second     = item_half;
        resp_data       = '0;
        resp_l1hit      = 1'b0;
        resp_pass       = 1'b0;
        if (state_q == ST_RESP) begin
            if (item_kind == K_SPEC) begin
                resp_data  = pick(line_q, rd_addr[3][OFF_W-1:0], rd_size[3]);
                resp_l1hit = local_q;
            end else if (item_kind == K_VALID) begin
                resp_pass = pick(rd_data[3], rd_addr[3][OFF_W-1:0], rd_size[3]) ==
                            pick(line_q, rd_addr[3][OFF_W-1:0], rd_size[3]);
            end
        end
    end
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int LD_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic [1:0]      req_status,
    input logic            err,
    input logic            cache_req_valid,
    input logic            cache_resp_valid,
    input logic            resp_valid,
    input logic [1:0]      resp_kind,
    input logic [LD_W-1:0] resp_data,
    input logic            resp_pass,
    input logic            fwd_valid
);
    // R2
    issue_then_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_status == 2'd1 && req_kind != 2'd1) |=> cache_req_valid);

    // R6
    fwd_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_status == 2'd1 && req_kind == 2'd1) |=> (fwd_valid && !cache_req_valid));

    // R8
    err_no_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !cache_req_valid);

    // R4
    resp_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(cache_resp_valid));

    // R10
    expose_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'd2) |-> (resp_data == '0 && !resp_pass));

    // R12
    resp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && req_valid) |-> (req_status == 2'd3 || err));
endmodule

bind spec_load_buffer slb_checker #(.LD_W(MAX_LD*8)) u_slb_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_status(req_status), .err(err), .cache_req_valid(cache_req_valid),
    .cache_resp_valid(cache_resp_valid), .resp_valid(resp_valid),
    .resp_kind(resp_kind), .resp_data(resp_data), .resp_pass(resp_pass),
    .fwd_valid(fwd_valid)
);

// File: tb/spec_load_buffer_bench.sv
module spec_load_buffer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [1:0]   req_kind = '0;
    logic [5:0]   req_slot = '0;
    logic         req_second = 1'b0;
    logic         req_split = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [3:0]   req_size = '0;
    logic [5:0]   req_src_slot = '0;
    logic [1:0]   req_status;
    logic         err;
    logic         cache_req_valid;
    logic [1:0]   cache_req_kind;
    logic [27:0]  cache_req_line;
    logic [6:0]   cache_req_idx;
    logic         cache_resp_valid = 1'b0;
    logic [27:0]  cache_resp_line = '0;
    logic [127:0] cache_resp_data = '0;
    logic         cache_resp_local = 1'b0;
    logic         resp_valid;
    logic [1:0]   resp_kind;
    logic [5:0]   resp_slot;
    logic         resp_second;
    logic [63:0]  resp_data;
    logic         resp_l1hit;
    logic         resp_pass;
    logic         fwd_valid;
    logic [5:0]   fwd_slot;
    logic         fwd_second;
    logic [63:0]  fwd_data;

    int total = 0;
    int bad = 0;
    logic [1:0] st;
    logic       er;

    always #4 clk = ~clk;

    spec_load_buffer u_spec_load_buffer (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] ramp(input logic [7:0] base);
        logic [127:0] d;
        for (int i = 0; i < 16; i++) d[8*i +: 8] = base + 8'(i);
        return d;
    endfunction

    // drive one request for one cycle; status captured before the edge
    task automatic send(input logic [1:0] k, input logic [5:0] s, input logic sec,
                        input logic spl, input logic [31:0] a, input logic [3:0] sz,
                        input logic [5:0] src);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_slot = s; req_second = sec;
        req_split = spl; req_addr = a; req_size = sz; req_src_slot = src;
        #1; st = req_status; er = err;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [27:0] ln, input logic [127:0] d, input logic loc);
        cache_resp_valid = 1'b1; cache_resp_line = ln;
        cache_resp_data = d; cache_resp_local = loc;
        @(posedge clk); #1;
        cache_resp_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 resp_valid", 128'(resp_valid), 0);
        chk("R1 fwd_valid", 128'(fwd_valid), 0);
        chk("R1 cache_req_valid", 128'(cache_req_valid), 0);
        send(2'd1, 6'd2, 1'b0, 1'b0, 32'h100, 4'd4, 6'd0);
        chk("R1 empty buffer-only err", 128'(er), 1);
    endtask

    task automatic t_spec_merge();
        send(2'd0, 6'd3, 1'b0, 1'b0, 32'h104, 4'd4, 6'd0);
        chk("R2 status issued", 128'(st), 1);
        chk("R2 cache_req_valid", 128'(cache_req_valid), 1);
        chk("R2 cache_req_idx", 128'(cache_req_idx), 6);
        chk("R2 cache_req_line", 128'(cache_req_line), 28'h10);
        chk("R2 cache_req_kind", 128'(cache_req_kind), 0);
        send(2'd0, 6'd5, 1'b1, 1'b1, 32'h108, 4'd2, 6'd0);
        chk("R3 same line merged", 128'(st), 2);
        send(2'd0, 6'd6, 1'b0, 1'b0, 32'h200, 4'd4, 6'd0);
        chk("R3 other line stalled", 128'(st), 3);
        send(2'd2, 6'd3, 1'b0, 1'b0, 32'h104, 4'd4, 6'd0);
        chk("R12 expose in wait stalled", 128'(st), 3);
        fill(28'h10, ramp(8'hA0), 1'b1);
        chk("R4 primary resp_valid", 128'(resp_valid), 1);
        chk("R4 primary slot", 128'(resp_slot), 3);
        chk("R4 primary data", 128'(resp_data), 64'hA7A6A5A4);
        chk("R5 l1hit local", 128'(resp_l1hit), 1);
        req_valid = 1'b1; req_kind = 2'd0; req_slot = 6'd8; req_second = 1'b0;
        req_split = 1'b0; req_addr = 32'h400; req_size = 4'd4;
        #1;
        chk("R12 request during response stalled", 128'(req_status), 3);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk("R4 dependent slot", 128'({resp_slot, resp_second}), {6'd5, 1'b1});
        chk("R4 dependent data", 128'(resp_data), 64'hA9A8);
        @(posedge clk); #1;
        chk("R4 drained", 128'(resp_valid), 0);
    endtask

    task automatic t_forward();
        send(2'd1, 6'd10, 1'b0, 1'b0, 32'h106, 4'd2, 6'd3);
        chk("R6 status issued", 128'(st), 1);
        chk("R6 fwd from half 0", 128'({fwd_valid, fwd_slot, fwd_data}), {1'b1, 6'd10, 64'hA7A6});
        chk("R6 no cache request", 128'(cache_req_valid), 0);
        send(2'd1, 6'd11, 1'b0, 1'b0, 32'h10C, 4'd4, 6'd5);
        chk("R6 fwd from half 1", 128'(fwd_data), 64'hAFAEADAC);
        send(2'd1, 6'd12, 1'b0, 1'b0, 32'h100, 4'd4, 6'd20);
        chk("R7 miss err", 128'({er, st}), {1'b1, 2'd0});
        chk("R7 no fwd", 128'(fwd_valid), 0);
    endtask

    task automatic t_guard();
        send(2'd0, 6'd7, 1'b0, 1'b0, 32'h300, 4'd4, 6'd0);
        send(2'd1, 6'd7, 1'b0, 1'b0, 32'h100, 4'd1, 6'd3);
        chk("R6 buffer-only accepted in wait", 128'(st), 1);
        fill(28'h30, {16{8'h55}}, 1'b0);
        chk("R5 l1hit clear", 128'(resp_l1hit), 0);
        @(posedge clk); #1;
        send(2'd1, 6'd12, 1'b0, 1'b0, 32'h100, 4'd1, 6'd7);
        chk("R4 mismatched line not written", 128'(fwd_data), 64'hA0);
    endtask

    task automatic t_validate();
        logic [127:0] alt;
        send(2'd3, 6'd3, 1'b0, 1'b0, 32'h104, 4'd4, 6'd0);
        chk("R2 validate cache kind", 128'({cache_req_kind, cache_req_idx}), {2'd3, 7'd6});
        fill(28'h10, ramp(8'hA0), 1'b1);
        chk("R9 equal pass", 128'({resp_kind, resp_pass}), {2'd3, 1'b1});
        @(posedge clk); #1;
        alt = ramp(8'hA0);
        alt[8*5 +: 8] = 8'h00;
        send(2'd3, 6'd3, 1'b0, 1'b0, 32'h104, 4'd4, 6'd0);
        fill(28'h10, alt, 1'b1);
        chk("R9 altered fail", 128'(resp_pass), 0);
        @(posedge clk); #1;
        send(2'd3, 6'd3, 1'b0, 1'b0, 32'h104, 4'd2, 6'd0);
        chk("R8 size mismatch err", 128'(er), 1);
        chk("R8 no cache request", 128'(cache_req_valid), 0);
    endtask

    task automatic t_expose();
        send(2'd2, 6'd5, 1'b1, 1'b1, 32'h108, 4'd2, 6'd0);
        chk("R2 expose idx", 128'({st, cache_req_idx}), {2'd1, 7'd11});
        fill(28'h10, ramp(8'hA0), 1'b1);
        chk("R10 expose response", 128'({resp_valid, resp_kind, resp_data, resp_pass}),
            {1'b1, 2'd2, 64'h0, 1'b0});
        @(posedge clk); #1;
        send(2'd2, 6'd5, 1'b1, 1'b0, 32'h108, 4'd2, 6'd0);
        chk("R11 second half without split", 128'({er, st}), {1'b1, 2'd0});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_spec_merge();
        t_forward();
        t_guard();
        t_validate();
        t_expose();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule